// File: doc/BRIEF.md
# Cluster CPU Power-Mode Sequencer

This block is the local power controller for a cluster of CPU cores, four by default. Each core runs its own sequencer. While a core is running, it chooses between a nominal-bias standby mode and a forward-body-bias performance mode. As soon as the core reports it is idle and waiting for an interrupt, the sequencer drops it into a low-leakage retention state, with the rail diode engaged and reverse body bias applied. A wake event brings the core back to full voltage after a fixed, configurable number of cycles. No context restore is needed, because state is retained.

If a core stays in retention past its own idle threshold, the sequencer escalates. It asks for a context save and, once the save is acknowledged, turns the core's switch fully off (hot-plug). Waking from hot-plug needs a power-up and a context restore. A wake that arrives during the save cancels the escalation.

When every core in the cluster sits in hot-plug, the cluster controller asks the external power-management device to remove the cluster rail. A later wake first withdraws that request and waits for a supply-good indication. Only then does the waking core run its restore sequence. The analog switches, the rail levels and the cache flush are represented only by their acknowledge inputs.

Top module: `cpu_pwr_seq`

## Requirements
- R1: After reset, every core reports status code 0, with the full switch on, diode off, both bias selects low and no save or restore request; the external-off request is low. Status codes per core: 0 standby, 1 forward bias, 2 retention, 3 hot-plug, 4 external-off, 5 waking from retention, 6 context save, 7 power-up or context restore.
- R2: A core in standby or forward bias that sees its idle input high enters retention at the next clock edge: status 2, full switch off, diode on, reverse bias selected.
- R3: A wake in retention moves the core to status 5 with the full switch on and no bias at the next edge. Exactly RESTORE_CYC cycles later it reports status 0, without issuing a restore request.
- R4: A core left in retention with no wake for max(threshold,1) cycles moves to status 6. In status 6 the save request is high and the full switch stays on.
- R5: A save acknowledge in status 6 moves the core to status 3 with all switches off at the next edge. The full switch never turns off toward the off state unless a save acknowledge was present in the previous cycle.
- R6: A wake in hot-plug with the cluster rail present gives status 7 with the full switch on and the restore request high. A restore acknowledge then returns the core to status 0.
- R7: When every core is in hot-plug and none has a wake, the external-off request rises at the next edge, and hot-plug cores report status 4 while the rail is not granted.
- R8: A wake while the rail is removed drops the external-off request at the next edge. The core reports status 7 with its switch off until the supply-good input is high. The restore request then rises two edges after supply-good is first seen.
- R9: A wake during a context save returns the core to status 0 at the next edge with no restore request.
- R10: A change of the performance input in an active mode switches the bias select at the next edge but keeps the old status for BIAS_CYC cycles. During that window, idle and performance inputs are ignored.
- R11: A core never has the full switch and the diode on together, nor reverse and forward bias together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wfi_i | input | NUM_CORES | Per-core idle (waiting for interrupt) |
| wake_i | input | NUM_CORES | Per-core wake: interrupt or snoop |
| perf_req_i | input | NUM_CORES | Per-core request for forward bias |
| idle_thresh_i | input | NUM_CORES*THRESH_W | Per-core retention cycles before hot-plug |
| save_done_i | input | NUM_CORES | Context save acknowledge |
| restore_done_i | input | NUM_CORES | Context restore acknowledge |
| ext_pwr_good_i | input | 1 | External cluster rail is good |
| sw_full_o | output | NUM_CORES | Power switch fully on |
| sw_diode_o | output | NUM_CORES | Retention diode engaged |
| bias_rev_o | output | NUM_CORES | Reverse body bias select |
| bias_fwd_o | output | NUM_CORES | Forward body bias select |
| save_req_o | output | NUM_CORES | Start context save |
| restore_req_o | output | NUM_CORES | Start context restore |
| ext_off_req_o | output | 1 | Ask external device to remove cluster rail |
| mode_o | output | NUM_CORES*3 | Per-core status code, core n at bits 3n+2:3n |

## Verification
A corrupted per-core state shows at the ports on the very next cycle. The status code and the switch and bias outputs are decoded directly from it, so an illegal pairing such as diode plus full switch, or a wrong code, is visible immediately. Timer faults appear as a status change one or more cycles early or late at the end of the retention, wake or bias-settle window. The bench checks these at exact cycles. A fault in the cluster rail grant shows as the external-off request rising while a core is still active or about to wake, or as a restore request issued before supply-good.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

  typedef enum logic [2:0] {
    MODE_STBY    = 3'd0,
    MODE_FBB     = 3'd1,
    MODE_RET     = 3'd2,
    MODE_HP      = 3'd3,
    MODE_EXT_OFF = 3'd4,
    MODE_WAKE    = 3'd5,
    MODE_SAVE    = 3'd6,
    MODE_RESTORE = 3'd7
  } pmode_e;

  typedef enum logic [3:0] {
    S_STBY, S_FBB, S_SETTLE, S_RET, S_WAKE, S_SAVE, S_HP, S_PWRUP, S_RESTORE
  } core_st_e;

  typedef enum logic [1:0] {CL_ON, CL_OFF, CL_RESUME} cl_st_e;

  typedef struct packed {
    logic full;
    logic diode;
    logic rbb;
    logic fbb;
    logic save;
    logic restore;
  } core_ctl_t;

endpackage

// File: rtl/core_pwr_fsm.sv
module core_pwr_fsm
  import pwr_seq_pkg::*;
#(
  parameter int THRESH_W    = 8,
  parameter int RESTORE_CYC = 16,
  parameter int BIAS_CYC    = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wfi_i,
  input  logic                wake_i,
  input  logic                perf_i,
  input  logic [THRESH_W-1:0] thresh_i,
  input  logic                save_done_i,
  input  logic                restore_done_i,
  input  logic                supply_ok_i,
  output core_st_e            state_o,
  output logic                tgt_fbb_o,
  output logic                hp_idle_o,
  output logic                up_req_o
);

  localparam int RCW   = $clog2(RESTORE_CYC + 1);
  localparam int BCW   = $clog2(BIAS_CYC + 1);
  localparam int TB_W  = (RCW > BCW) ? RCW : BCW;
  localparam int CNT_W = (THRESH_W > TB_W) ? THRESH_W : TB_W;
  localparam logic [CNT_W-1:0] WAKE_LAST = CNT_W'(RESTORE_CYC - 1);
  localparam logic [CNT_W-1:0] BIAS_LAST = CNT_W'(BIAS_CYC - 1);

  core_st_e         state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             tgt_q, tgt_d;
  logic [CNT_W:0]   run_len, thr_ext;

  // cycles spent in current state, counting the entry cycle
  assign run_len = {1'b0, cnt_q} + (CNT_W+1)'(1);
  assign thr_ext = (CNT_W+1)'(thresh_i);

  always_comb begin
    state_d = state_q;
    tgt_d   = tgt_q;
    unique case (state_q)
      S_STBY: begin
        if (wfi_i) state_d = S_RET;
        else if (perf_i) begin
          state_d = S_SETTLE;
          tgt_d   = 1'b1;
        end
      end
      S_FBB: begin
        if (wfi_i) state_d = S_RET;
        else if (!perf_i) begin
          state_d = S_SETTLE;
          tgt_d   = 1'b0;
        end
      end
      S_SETTLE:  if (cnt_q >= BIAS_LAST) state_d = tgt_q ? S_FBB : S_STBY;
      S_RET: begin
        if (wake_i) state_d = S_WAKE;
        else if (run_len >= thr_ext) state_d = S_SAVE;
      end
      S_WAKE:    if (cnt_q >= WAKE_LAST) state_d = S_STBY;
      S_SAVE: begin
        if (wake_i) state_d = S_STBY;
        else if (save_done_i) state_d = S_HP;
      end
      S_HP:      if (wake_i) state_d = supply_ok_i ? S_RESTORE : S_PWRUP;
      S_PWRUP:   if (supply_ok_i) state_d = S_RESTORE;
      S_RESTORE: if (restore_done_i) state_d = S_STBY;
      default:   state_d = S_STBY;
    endcase
  end

  always_comb begin
    if (state_d != state_q) cnt_d = '0;
    else if (&cnt_q)        cnt_d = cnt_q;
    else                    cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_STBY;
      cnt_q   <= '0;
      tgt_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      tgt_q   <= tgt_d;
    end
  end

  assign state_o   = state_q;
  assign tgt_fbb_o = tgt_q;
  assign hp_idle_o = (state_q == S_HP) && !wake_i;
  assign up_req_o  = ((state_q == S_HP) && wake_i) || (state_q == S_PWRUP);

  AST_RET_ON_WFI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == S_STBY || state_q == S_FBB) && wfi_i) |=> (state_q == S_RET)); // R2

  AST_SAVE_ABORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_SAVE && wake_i) |=> (state_q == S_STBY)); // R9

  AST_SETTLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_SETTLE && cnt_q < BIAS_LAST) |=> (state_q == S_SETTLE)); // R10

  AST_PWRUP_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_PWRUP && !supply_ok_i) |=> (state_q == S_PWRUP)); // R8

endmodule

// File: rtl/core_out_map.sv
module core_out_map
  import pwr_seq_pkg::*;
(
  input  core_st_e  state_i,
  input  logic      tgt_fbb_i,
  input  logic      supply_ok_i,
  output core_ctl_t ctl_o,
  output pmode_e    mode_o
);

  always_comb begin
    ctl_o  = '0;
    mode_o = MODE_STBY;
    unique case (state_i)
      S_STBY: ctl_o.full = 1'b1;
      S_FBB: begin
        ctl_o.full = 1'b1;
        ctl_o.fbb  = 1'b1;
        mode_o     = MODE_FBB;
      end
      S_SETTLE: begin
        // bias already at target, status still shows the mode being left
        ctl_o.full = 1'b1;
        ctl_o.fbb  = tgt_fbb_i;
        mode_o     = tgt_fbb_i ? MODE_STBY : MODE_FBB;
      end
      S_RET: begin
        ctl_o.diode = 1'b1;
        ctl_o.rbb   = 1'b1;
        mode_o      = MODE_RET;
      end
      S_WAKE: begin
        ctl_o.full = 1'b1;
        mode_o     = MODE_WAKE;
      end
      S_SAVE: begin
        ctl_o.full = 1'b1;
        ctl_o.save = 1'b1;
        mode_o     = MODE_SAVE;
      end
      S_HP:    mode_o = supply_ok_i ? MODE_HP : MODE_EXT_OFF;
      S_PWRUP: mode_o = MODE_RESTORE;
      S_RESTORE: begin
        ctl_o.full    = 1'b1;
        ctl_o.restore = 1'b1;
        mode_o        = MODE_RESTORE;
      end
      default: ctl_o = '0;
    endcase
  end

endmodule

// File: rtl/cluster_supply_ctl.sv
module cluster_supply_ctl
  import pwr_seq_pkg::*;
#(
  parameter int NUM_CORES = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_CORES-1:0] hp_idle_i,
  input  logic [NUM_CORES-1:0] up_req_i,
  input  logic                 ext_pwr_good_i,
  output logic                 supply_ok_o,
  output logic                 ext_off_req_o
);

  cl_st_e cl_q, cl_d;

  always_comb begin
    cl_d = cl_q;
    unique case (cl_q)
      CL_ON:     if (&hp_idle_i) cl_d = CL_OFF;
      CL_OFF:    if (|up_req_i) cl_d = CL_RESUME;
      CL_RESUME: if (ext_pwr_good_i) cl_d = CL_ON;
      default:   cl_d = CL_ON;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cl_q <= CL_ON;
    else         cl_q <= cl_d;
  end

  assign supply_ok_o   = (cl_q == CL_ON);
  assign ext_off_req_o = (cl_q == CL_OFF);

  AST_EXT_ALL_HP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ext_off_req_o) |-> $past(&hp_idle_i)); // R7

  AST_RESUME_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cl_q == CL_RESUME && !ext_pwr_good_i) |=> !supply_ok_o && !ext_off_req_o); // R8

endmodule

// File: rtl/cpu_pwr_seq.sv
module cpu_pwr_seq
  import pwr_seq_pkg::*;
#(
  parameter int NUM_CORES   = 4,
  parameter int THRESH_W    = 8,
  parameter int RESTORE_CYC = 16,
  parameter int BIAS_CYC    = 4
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [NUM_CORES-1:0]          wfi_i,
  input  logic [NUM_CORES-1:0]          wake_i,
  input  logic [NUM_CORES-1:0]          perf_req_i,
  input  logic [NUM_CORES*THRESH_W-1:0] idle_thresh_i,
  input  logic [NUM_CORES-1:0]          save_done_i,
  input  logic [NUM_CORES-1:0]          restore_done_i,
  input  logic                          ext_pwr_good_i,
  output logic [NUM_CORES-1:0]          sw_full_o,
  output logic [NUM_CORES-1:0]          sw_diode_o,
  output logic [NUM_CORES-1:0]          bias_rev_o,
  output logic [NUM_CORES-1:0]          bias_fwd_o,
  output logic [NUM_CORES-1:0]          save_req_o,
  output logic [NUM_CORES-1:0]          restore_req_o,
  output logic                          ext_off_req_o,
  output logic [NUM_CORES*3-1:0]        mode_o
);

  logic [NUM_CORES-1:0] hp_idle, up_req;
  logic                 supply_ok;

  cluster_supply_ctl #(.NUM_CORES(NUM_CORES)) u_cluster (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .hp_idle_i      (hp_idle),
    .up_req_i       (up_req),
    .ext_pwr_good_i (ext_pwr_good_i),
    .supply_ok_o    (supply_ok),
    .ext_off_req_o  (ext_off_req_o)
  );

  for (genvar g = 0; g < NUM_CORES; g++) begin : g_core
    core_st_e  st;
    logic      tgt_fbb;
    core_ctl_t ctl;
    pmode_e    mode;

    core_pwr_fsm #(
      .THRESH_W    (THRESH_W),
      .RESTORE_CYC (RESTORE_CYC),
      .BIAS_CYC    (BIAS_CYC)
    ) u_fsm (
      .clk_i          (clk_i),
      .rst_ni         (rst_ni),
      .wfi_i          (wfi_i[g]),
      .wake_i         (wake_i[g]),
      .perf_i         (perf_req_i[g]),
      .thresh_i       (idle_thresh_i[g*THRESH_W +: THRESH_W]),
      .save_done_i    (save_done_i[g]),
      .restore_done_i (restore_done_i[g]),
      .supply_ok_i    (supply_ok),
      .state_o        (st),
      .tgt_fbb_o      (tgt_fbb),
      .hp_idle_o      (hp_idle[g]),
      .up_req_o       (up_req[g])
    );

    core_out_map u_map (
      .state_i     (st),
      .tgt_fbb_i   (tgt_fbb),
      .supply_ok_i (supply_ok),
      .ctl_o       (ctl),
      .mode_o      (mode)
    );

    assign sw_full_o[g]     = ctl.full;
    assign sw_diode_o[g]    = ctl.diode;
    assign bias_rev_o[g]    = ctl.rbb;
    assign bias_fwd_o[g]    = ctl.fbb;
    assign save_req_o[g]    = ctl.save;
    assign restore_req_o[g] = ctl.restore;
    assign mode_o[g*3 +: 3] = mode;

    AST_SW_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(sw_full_o[g] && sw_diode_o[g])); // R11

    AST_BIAS_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(bias_rev_o[g] && bias_fwd_o[g])); // R11

    AST_OFF_AFTER_SAVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($fell(sw_full_o[g]) && !sw_diode_o[g]) |-> $past(save_done_i[g])); // R5

    AST_RESTORE_RAIL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(restore_req_o[g]) |-> !ext_off_req_o); // R8
  end

endmodule

// File: tb/cpu_pwr_seq_bench.sv
`timescale 1ns/1ps
module cpu_pwr_seq_bench;

  localparam int N  = 4;
  localparam int TW = 8;
  localparam int RC = 6;
  localparam int BC = 3;

  localparam int F_MODE = 0, F_FULL = 1, F_DIODE = 2, F_RBB = 3, F_FBB = 4,
                 F_SAVE = 5, F_REST = 6, F_EXT = 7;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  wfi = '0, wake = '0, perf = '0, sdone = '0, rdone = '0;
  logic [N*TW-1:0] thr = '0;
  logic          pgood = 1'b1;
  logic [N-1:0]  sw_full, sw_diode, b_rev, b_fwd, s_req, r_req;
  logic          ext_req;
  logic [N*3-1:0] mode;

  int cyc_cnt = 0;
  int n_checks = 0;
  int n_fail = 0;
  int excl_bad = 0;
  bit done = 1'b0;

  typedef struct {
    int cyc;
    int req;
    int sel;
    int core;
    int val;
  } item_t;
  item_t sb_q[$];

  cpu_pwr_seq #(
    .NUM_CORES(N), .THRESH_W(TW), .RESTORE_CYC(RC), .BIAS_CYC(BC)
  ) u_cpu_pwr_seq (
    .clk_i(clk), .rst_ni(rst_n), .wfi_i(wfi), .wake_i(wake), .perf_req_i(perf),
    .idle_thresh_i(thr), .save_done_i(sdone), .restore_done_i(rdone),
    .ext_pwr_good_i(pgood), .sw_full_o(sw_full), .sw_diode_o(sw_diode),
    .bias_rev_o(b_rev), .bias_fwd_o(b_fwd), .save_req_o(s_req),
    .restore_req_o(r_req), .ext_off_req_o(ext_req), .mode_o(mode)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) cyc_cnt <= cyc_cnt + 1;

  function automatic int obs(int sel, int core);
    case (sel)
      F_MODE:  return int'(mode[core*3 +: 3]);
      F_FULL:  return int'(sw_full[core]);
      F_DIODE: return int'(sw_diode[core]);
      F_RBB:   return int'(b_rev[core]);
      F_FBB:   return int'(b_fwd[core]);
      F_SAVE:  return int'(s_req[core]);
      F_REST:  return int'(r_req[core]);
      default: return int'(ext_req);
    endcase
  endfunction

  // monitor: pop due items and compare
  always @(negedge clk) begin
    int idx;
    idx = 0;
    while (idx < sb_q.size()) begin
      if (sb_q[idx].cyc <= cyc_cnt) begin
        n_checks++;
        if (sb_q[idx].cyc < cyc_cnt || obs(sb_q[idx].sel, sb_q[idx].core) != sb_q[idx].val) begin
          n_fail++;
          $display("FAIL R%0d cyc %0d field %0d core %0d: actual %0d expected %0d",
                   sb_q[idx].req, cyc_cnt, sb_q[idx].sel, sb_q[idx].core,
                   obs(sb_q[idx].sel, sb_q[idx].core), sb_q[idx].val);
        end
        sb_q.delete(idx);
      end else begin
        idx++;
      end
    end
    if (rst_n) begin
      for (int c = 0; c < N; c++)
        if ((sw_full[c] && sw_diode[c]) || (b_rev[c] && b_fwd[c])) excl_bad++;
    end
  end

  task automatic exp_at(int dn, int req, int sel, int core, int val);
    item_t it;
    it.cyc = cyc_cnt + dn;
    it.req = req;
    it.sel = sel;
    it.core = core;
    it.val = val;
    sb_q.push_back(it);
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    n_checks++; // R11: exclusivity held on every cycle
    if (excl_bad != 0) begin
      n_fail++;
      $display("FAIL R11 exclusive switch/bias violated: actual %0d expected 0", excl_bad);
    end
    if (sb_q.size() != 0) begin
      n_fail += sb_q.size();
      n_checks += sb_q.size();
      $display("FAIL R0 scoreboard not drained: actual %0d expected 0", sb_q.size());
    end
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired: actual hung expected done");
      finish_run();
    end
  end

  initial begin
    for (int c = 0; c < N; c++) thr[c*TW +: TW] = 8'd200;
    wait_n(3);
    rst_n = 1'b1;

    // R1 reset state
    for (int c = 0; c < N; c++) begin
      exp_at(1, 1, F_MODE, c, 0);
      exp_at(1, 1, F_FULL, c, 1);
      exp_at(1, 1, F_DIODE, c, 0);
      exp_at(1, 1, F_RBB, c, 0);
      exp_at(1, 1, F_FBB, c, 0);
      exp_at(1, 1, F_SAVE, c, 0);
      exp_at(1, 1, F_REST, c, 0);
    end
    exp_at(1, 1, F_EXT, 0, 0);
    wait_n(2);

    // R2 retention on idle, R3 timed wake
    wfi[0] = 1'b1;
    exp_at(1, 2, F_MODE, 0, 2);
    exp_at(1, 2, F_DIODE, 0, 1);
    exp_at(1, 2, F_FULL, 0, 0);
    exp_at(1, 2, F_RBB, 0, 1);
    wait_n(3);
    wake[0] = 1'b1;
    wfi[0] = 1'b0;
    exp_at(1, 3, F_MODE, 0, 5);
    exp_at(1, 3, F_FULL, 0, 1);
    exp_at(1, 3, F_RBB, 0, 0);
    wait_n(1);
    wake[0] = 1'b0;
    exp_at(RC - 1, 3, F_MODE, 0, 5);
    exp_at(RC, 3, F_MODE, 0, 0);
    exp_at(RC, 3, F_REST, 0, 0);
    wait_n(RC + 1);

    // R4 threshold escalation, R9 abort during save
    thr[1*TW +: TW] = 8'd3;
    wfi[1] = 1'b1;
    exp_at(3, 4, F_MODE, 1, 2);
    exp_at(4, 4, F_MODE, 1, 6);
    exp_at(4, 4, F_SAVE, 1, 1);
    exp_at(4, 4, F_FULL, 1, 1);
    wait_n(4);
    wake[1] = 1'b1;
    wfi[1] = 1'b0;
    exp_at(1, 9, F_MODE, 1, 0);
    exp_at(1, 9, F_REST, 1, 0);
    exp_at(1, 9, F_SAVE, 1, 0);
    wait_n(1);
    wake[1] = 1'b0;
    wait_n(2);

    // R5 save acknowledge to hot-plug
    wfi[1] = 1'b1;
    wait_n(4);
    sdone[1] = 1'b1;
    exp_at(1, 5, F_MODE, 1, 3);
    exp_at(1, 5, F_FULL, 1, 0);
    exp_at(1, 5, F_DIODE, 1, 0);
    exp_at(1, 5, F_SAVE, 1, 0);
    wait_n(1);
    sdone[1] = 1'b0;
    exp_at(2, 5, F_MODE, 1, 3);
    wait_n(2);

    // R6 wake from hot-plug with rail present
    wake[1] = 1'b1;
    wfi[1] = 1'b0;
    exp_at(1, 6, F_MODE, 1, 7);
    exp_at(1, 6, F_REST, 1, 1);
    exp_at(1, 6, F_FULL, 1, 1);
    wait_n(1);
    wake[1] = 1'b0;
    wait_n(2);
    rdone[1] = 1'b1;
    exp_at(1, 6, F_MODE, 1, 0);
    exp_at(1, 6, F_REST, 1, 0);
    wait_n(1);
    rdone[1] = 1'b0;
    wait_n(1);

    // R10 bias settle; idle and perf changes ignored inside window
    perf[2] = 1'b1;
    exp_at(1, 10, F_FBB, 2, 1);
    exp_at(1, 10, F_MODE, 2, 0);
    exp_at(BC, 10, F_MODE, 2, 0);
    exp_at(BC + 1, 10, F_MODE, 2, 1);
    exp_at(BC + 1, 10, F_FBB, 2, 1);
    wait_n(1);
    wfi[2] = 1'b1;
    perf[2] = 1'b0;
    exp_at(1, 10, F_DIODE, 2, 0);
    exp_at(1, 10, F_MODE, 2, 0);
    wait_n(1);
    wfi[2] = 1'b0;
    perf[2] = 1'b1;
    wait_n(3);
    perf[2] = 1'b0;
    exp_at(1, 10, F_FBB, 2, 0);
    exp_at(1, 10, F_MODE, 2, 1);
    exp_at(BC + 1, 10, F_MODE, 2, 0);
    wait_n(BC + 2);

    // R7 whole cluster to hot-plug, external-off request
    for (int c = 0; c < N; c++) thr[c*TW +: TW] = 8'd2;
    wfi = '1;
    wait_n(5);
    sdone = '1;
    exp_at(1, 7, F_MODE, 0, 3);
    exp_at(1, 7, F_EXT, 0, 0);
    for (int c = 0; c < N; c++) exp_at(2, 7, F_MODE, c, 4);
    exp_at(2, 7, F_EXT, 0, 1);
    wait_n(1);
    sdone = '0;
    wait_n(3);
    pgood = 1'b0;
    wait_n(2);

    // R8 wake while rail removed
    wake[3] = 1'b1;
    wfi[3] = 1'b0;
    exp_at(1, 8, F_MODE, 3, 7);
    exp_at(1, 8, F_EXT, 0, 0);
    exp_at(1, 8, F_FULL, 3, 0);
    exp_at(1, 8, F_MODE, 0, 4);
    wait_n(1);
    wake[3] = 1'b0;
    wait_n(3);
    exp_at(1, 8, F_MODE, 3, 7);
    exp_at(1, 8, F_FULL, 3, 0);
    exp_at(1, 8, F_REST, 3, 0);
    wait_n(1);
    pgood = 1'b1;
    exp_at(1, 8, F_MODE, 0, 3);
    exp_at(1, 8, F_REST, 3, 0);
    exp_at(2, 8, F_REST, 3, 1);
    exp_at(2, 8, F_FULL, 3, 1);
    wait_n(3);
    rdone[3] = 1'b1;
    exp_at(1, 8, F_MODE, 3, 0);
    exp_at(1, 8, F_EXT, 0, 0);
    wait_n(1);
    rdone[3] = 1'b0;
    wait_n(3);

    done = 1'b1;
    finish_run();
  end

endmodule